// File: doc/BRIEF.md
# Latched Fault Protection Controller

This block sits between the threshold comparators of a step-down switching converter and its gate drivers. It decides what the switches must do when a fault flag is raised. The block accepts already-digitised flags: output too high, output too low, a low-side over-current event, the hot and cooled temperature thresholds, a signal saying undervoltage monitoring is armed, the enable input and the bias-supply-good signal. From these it drives a two-bit gate override, a one-cycle soft-start restart request and a three-bit fault cause code.

Each fault class has its own response. A persistent high output is filtered and then latches the low-side switch on to discharge the output. A persistent low output, when armed, is filtered and then latches both switches off. Every over-current event briefly turns the switches off and asks for a new soft-start. The event that reaches the configured count instead leaves both switches floating and latches. Over-temperature turns both switches off and releases on its own once the cool threshold is reported. Latched faults and the over-current tally are cleared only by dropping enable or by losing the bias supply.

Top module: `prot_fault_ctrl`

## Requirements
- R1: After reset `gate_mode_o` is 0 (normal switching), `fault_code_o` is 0 (no fault) and `ss_restart_o` is 0.
- R2: When `ov_flag_i` has been high on OV_FILTER_CYCLES consecutive rising edges, `gate_mode_o` becomes 2 (low-side forced on) and `fault_code_o` becomes 1 after that edge. Both stay so after the flag drops.
- R3: A filter counter returns to zero whenever its flag is low at an edge. A flag that drops one cycle short of its filter time has no effect, and a full new interval is needed afterwards.
- R4: When `uv_flag_i` and `uv_arm_i` are both high on UV_FILTER_CYCLES consecutive edges, `gate_mode_o` becomes 1 (both off) and `fault_code_o` becomes 3. The state is latched. With `uv_arm_i` low, `uv_flag_i` has no effect.
- R5: An over-current event (`oc_evt_i` high at an edge) below the latching count gives `ss_restart_o` high for the following cycle. During that cycle `gate_mode_o` is 1, and `fault_code_o` stays 0.
- R6: The event that reaches OC_LATCH_EVENTS (default 4) gives `gate_mode_o` 3 (both floating) and `fault_code_o` 4, with no restart pulse. The state is latched, and further events change nothing.
- R7: The over-current tally is not cleared by restarts or idle time, so events spread over time still add up to the latching count.
- R8: `ot_hot_i` at an edge gives `gate_mode_o` 1 and `fault_code_o` 2 from the next cycle. This holds while the flag later drops. It releases by itself to 0/0 one edge after `ot_cool_i` is seen high with `ot_hot_i` low.
- R9: Enable low or `bias_ok_i` low at an edge clears all latched faults, the filter counters and the over-current tally. After this, `fault_code_o` is 0 unless over-temperature is active.
- R10: Only the highest-priority active fault drives the outputs, in the order high output (code 1), over-temperature (2), low output (3), over-current (4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Converter enable; low clears latches |
| bias_ok_i | input | 1 | Bias supply good; low clears latches |
| ov_flag_i | input | 1 | Output above the high threshold |
| uv_flag_i | input | 1 | Output below the low threshold |
| uv_arm_i | input | 1 | Undervoltage monitoring armed (soft-start done) |
| oc_evt_i | input | 1 | One-cycle low-side current-limit event |
| ot_hot_i | input | 1 | Temperature above the trip threshold |
| ot_cool_i | input | 1 | Temperature below the release threshold |
| gate_mode_o | output | 2 | 0 run, 1 both off, 2 low-side on, 3 both floating |
| ss_restart_o | output | 1 | One-cycle soft-start restart request |
| fault_code_o | output | 3 | 0 none, 1 high output, 2 over-temp, 3 low output, 4 over-current |

## Verification
The hardest state to reach is several faults held at once, because the outputs show only the winner. The stimulus first latches a low output through its full filter window. It then raises over-temperature and after that a filtered high output. At each step it checks that the outputs move to the new winner, and after over-temperature releases it checks that the latched high-output response remains. The over-current tally is reached by spacing events apart with idle gaps, so that only an accumulating count can latch on the last event. A bias-supply drop in the middle of this sequence shows that the tally was emptied.

// File: rtl/prot_pkg.sv
// Package: shared encodings for the fault protection controller.
// Assumes: gate override and cause code values are part of the port contract.
package prot_pkg;

    typedef enum logic [1:0] {
        GATE_RUN     = 2'd0,
        GATE_ALL_OFF = 2'd1,
        GATE_LS_ON   = 2'd2,
        GATE_FLOAT   = 2'd3
    } gate_e;

    typedef enum logic [2:0] {
        CAUSE_NONE = 3'd0,
        CAUSE_OV   = 3'd1,
        CAUSE_OT   = 3'd2,
        CAUSE_UV   = 3'd3,
        CAUSE_OC   = 3'd4
    } cause_e;

endpackage

// File: rtl/fault_filter.sv
// Module: fault_filter
// Counts consecutive cycles with flag_i high and raises trip_o during the
// cycle in which the flag is high for the HOLD_CYCLES-th time in a row.
// Assumes: HOLD_CYCLES >= 1; clr_i empties the counter like a low flag.
module fault_filter #(
    parameter int HOLD_CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic flag_i,
    output logic trip_o
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    // Trip when the flag is present and all earlier cycles of the window were.
    assign trip_o = flag_i && (cnt_q == LAST);

    // Consecutive-high counter, saturating at the last window position.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i || !flag_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_FILT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_i |=> cnt_q == '0); // R3

    AST_FILT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST); // R3

endmodule

// File: rtl/oc_event_counter.sv
// Module: oc_event_counter
// Tallies low-side current-limit events. Each accepted event below the limit
// issues a one-cycle restart request; the event reaching EVENTS_TO_LATCH sets
// a sticky latch instead.
// Assumes: clr_i (enable low or bias loss) is the only way to empty the tally.
module oc_event_counter #(
    parameter int EVENTS_TO_LATCH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic evt_i,
    input  logic hold_i,
    output logic restart_o,
    output logic latch_o
);
    localparam int CW = $clog2(EVENTS_TO_LATCH + 1);
    localparam logic [CW-1:0] FINAL_IDX = CW'(EVENTS_TO_LATCH - 1);

    logic [CW-1:0] cnt_q;
    logic          lat_q;
    logic          restart_q;
    logic          accept;

    // An event counts only while no latch already owns the switches.
    assign accept = evt_i && !hold_i && !lat_q && !clr_i;

    // Event tally and sticky latch; restarts never rewind the tally.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_q     <= '0;
            lat_q     <= 1'b0;
            restart_q <= 1'b0;
        end else begin
            restart_q <= 1'b0;
            if (accept) begin
                if (cnt_q == FINAL_IDX) begin
                    lat_q <= 1'b1;
                end else begin
                    cnt_q     <= cnt_q + 1'b1;
                    restart_q <= 1'b1;
                end
            end
        end
    end

    assign restart_o = restart_q;
    assign latch_o   = lat_q;

    AST_OC_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FINAL_IDX); // R7

    AST_OC_NO_RESTART_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        restart_q |-> !lat_q); // R6

    AST_OC_LATCH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lat_q) |-> $past(evt_i)); // R6

endmodule

// File: rtl/thermal_hold.sv
// Module: thermal_hold
// Holds a non-latching over-temperature state from the hot report until the
// cooled report, giving the hysteresis band between the two thresholds.
// Assumes: only the system reset clears it; enable has no say over heat.
module thermal_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic hot_i,
    input  logic cool_i,
    output logic active_o
);
    logic ot_q;

    // Set on hot, release on cool; hot wins if both are reported.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ot_q <= 1'b0;
        end else if (hot_i) begin
            ot_q <= 1'b1;
        end else if (cool_i) begin
            ot_q <= 1'b0;
        end
    end

    assign active_o = ot_q;

    AST_OT_SET_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ot_q) |-> $past(hot_i)); // R8

    AST_OT_RELEASE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ot_q) |-> ($past(cool_i) && !$past(hot_i))); // R8

endmodule

// File: rtl/fault_arbiter.sv
// Module: fault_arbiter
// Combinational priority pick: high output, over-temperature, low output,
// over-current latch, then a pending restart; the winner sets gate and code.
// Assumes: inputs are registered state, so outputs are glitch-free per cycle.
module fault_arbiter
    import prot_pkg::*;
(
    input  logic   ov_i,
    input  logic   ot_i,
    input  logic   uv_i,
    input  logic   oc_i,
    input  logic   restart_i,
    output gate_e  gate_o,
    output cause_e cause_o
);
    // Priority resolution of the active causes.
    always_comb begin
        gate_o  = GATE_RUN;
        cause_o = CAUSE_NONE;
        if (ov_i) begin
            gate_o  = GATE_LS_ON;
            cause_o = CAUSE_OV;
        end else if (ot_i) begin
            gate_o  = GATE_ALL_OFF;
            cause_o = CAUSE_OT;
        end else if (uv_i) begin
            gate_o  = GATE_ALL_OFF;
            cause_o = CAUSE_UV;
        end else if (oc_i) begin
            gate_o  = GATE_FLOAT;
            cause_o = CAUSE_OC;
        end else if (restart_i) begin
            gate_o  = GATE_ALL_OFF;
        end
    end

endmodule

// File: rtl/prot_fault_ctrl.sv
// Module: prot_fault_ctrl (top)
// Fault response controller for a step-down converter: filters the voltage
// flags, latches their responses, tallies current-limit events, tracks the
// thermal hold and resolves one gate override and one cause code.
// Assumes: all inputs are synchronous to clk; filter lengths are in cycles.
module prot_fault_ctrl
    import prot_pkg::*;
#(
    parameter int OV_FILTER_CYCLES = 200,
    parameter int UV_FILTER_CYCLES = 3000,
    parameter int OC_LATCH_EVENTS  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       bias_ok_i,
    input  logic       ov_flag_i,
    input  logic       uv_flag_i,
    input  logic       uv_arm_i,
    input  logic       oc_evt_i,
    input  logic       ot_hot_i,
    input  logic       ot_cool_i,
    output logic [1:0] gate_mode_o,
    output logic       ss_restart_o,
    output logic [2:0] fault_code_o
);
    localparam int N_FILT = 2;
    localparam int IDX_OV = 0;
    localparam int IDX_UV = 1;

    logic              clr;
    logic [N_FILT-1:0] filt_in;
    logic [N_FILT-1:0] filt_trip;
    logic              ov_lat_q;
    logic              uv_lat_q;
    logic              oc_lat;
    logic              oc_restart;
    logic              ot_active;
    gate_e             gate_sel;
    cause_e            cause_sel;

    // Latch clearing: enable low or bias supply lost.
    assign clr = !en_i || !bias_ok_i;

    // Undervoltage is only observed while monitoring is armed.
    assign filt_in[IDX_OV] = ov_flag_i;
    assign filt_in[IDX_UV] = uv_flag_i && uv_arm_i;

    // One debounce filter per voltage fault, each with its own window.
    for (genvar g = 0; g < N_FILT; g++) begin : g_filt
        localparam int WIN = (g == IDX_OV) ? OV_FILTER_CYCLES : UV_FILTER_CYCLES;
        fault_filter #(
            .HOLD_CYCLES(WIN)
        ) filt_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr_i  (clr),
            .flag_i (filt_in[g]),
            .trip_o (filt_trip[g])
        );
    end

    // Sticky voltage-fault latches set by their filter trips.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ov_lat_q <= 1'b0;
            uv_lat_q <= 1'b0;
        end else begin
            if (filt_trip[IDX_OV]) ov_lat_q <= 1'b1;
            if (filt_trip[IDX_UV]) uv_lat_q <= 1'b1;
        end
    end

    oc_event_counter #(
        .EVENTS_TO_LATCH(OC_LATCH_EVENTS)
    ) occ_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (clr),
        .evt_i     (oc_evt_i),
        .hold_i    (ov_lat_q || uv_lat_q || ot_active),
        .restart_o (oc_restart),
        .latch_o   (oc_lat)
    );

    thermal_hold oth_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .hot_i    (ot_hot_i),
        .cool_i   (ot_cool_i),
        .active_o (ot_active)
    );

    fault_arbiter arb_i (
        .ov_i      (ov_lat_q),
        .ot_i      (ot_active),
        .uv_i      (uv_lat_q),
        .oc_i      (oc_lat),
        .restart_i (oc_restart),
        .gate_o    (gate_sel),
        .cause_o   (cause_sel)
    );

    assign gate_mode_o  = gate_sel;
    assign fault_code_o = cause_sel;
    assign ss_restart_o = oc_restart && !ov_lat_q && !ot_active && !uv_lat_q;

    AST_CLEAR_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i || !bias_ok_i) |=> (fault_code_o == CAUSE_NONE || fault_code_o == CAUSE_OT)); // R9

    AST_OV_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ov_lat_q && en_i && bias_ok_i) |=> gate_mode_o == GATE_LS_ON); // R2

    AST_UV_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(uv_lat_q) |-> $past(uv_arm_i)); // R4

    AST_RESTART_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ss_restart_o |-> (gate_mode_o == GATE_ALL_OFF && fault_code_o == CAUSE_NONE)); // R5

    AST_OT_WINS_UV: assert property (@(posedge clk) disable iff (!rst_n)
        (ot_active && !ov_lat_q) |-> fault_code_o == CAUSE_OT); // R10

endmodule

// File: tb/prot_fault_ctrl_tb_top.sv
module prot_fault_ctrl_tb_top;

    localparam int OVW = 200;
    localparam int UVW = 3000;
    localparam int OCN = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_i = 1'b1;
    logic       bias_ok_i = 1'b1;
    logic       ov_flag_i = 1'b0;
    logic       uv_flag_i = 1'b0;
    logic       uv_arm_i = 1'b0;
    logic       oc_evt_i = 1'b0;
    logic       ot_hot_i = 1'b0;
    logic       ot_cool_i = 1'b0;
    logic [1:0] gate_mode_o;
    logic       ss_restart_o;
    logic [2:0] fault_code_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    prot_fault_ctrl #(
        .OV_FILTER_CYCLES(OVW),
        .UV_FILTER_CYCLES(UVW),
        .OC_LATCH_EVENTS (OCN)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (en_i),
        .bias_ok_i    (bias_ok_i),
        .ov_flag_i    (ov_flag_i),
        .uv_flag_i    (uv_flag_i),
        .uv_arm_i     (uv_arm_i),
        .oc_evt_i     (oc_evt_i),
        .ot_hot_i     (ot_hot_i),
        .ot_cool_i    (ot_cool_i),
        .gate_mode_o  (gate_mode_o),
        .ss_restart_o (ss_restart_o),
        .fault_code_o (fault_code_o)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic expect_out(input string req, input int gate, input int code, input int rs);
        check(req, "gate", int'(gate_mode_o), gate);
        check(req, "code", int'(fault_code_o), code);
        check(req, "restart", int'(ss_restart_o), rs);
    endtask

    task automatic toggle_enable();
        en_i = 1'b0;
        step(1);
        en_i = 1'b1;
        step(1);
    endtask

    task automatic oc_pulse();
        oc_evt_i = 1'b1;
        step(1);
        oc_evt_i = 1'b0;
    endtask

    task automatic t_reset();
        expect_out("R1", 0, 0, 0);
    endtask

    task automatic t_ov();
        ov_flag_i = 1'b1;
        step(OVW - 1);
        expect_out("R2", 0, 0, 0);
        step(1);
        expect_out("R2", 2, 1, 0);
        ov_flag_i = 1'b0;
        step(5);
        expect_out("R2", 2, 1, 0);
        en_i = 1'b0;
        step(1);
        expect_out("R9", 0, 0, 0);
        en_i = 1'b1;
        step(1);
    endtask

    task automatic t_filter_restart();
        ov_flag_i = 1'b1;
        step(OVW - 1);
        ov_flag_i = 1'b0;
        step(1);
        ov_flag_i = 1'b1;
        step(OVW - 1);
        expect_out("R3", 0, 0, 0);
        step(1);
        expect_out("R3", 2, 1, 0);
        ov_flag_i = 1'b0;
        toggle_enable();
        expect_out("R9", 0, 0, 0);
    endtask

    task automatic t_uv();
        uv_arm_i  = 1'b0;
        uv_flag_i = 1'b1;
        step(UVW + 10);
        expect_out("R4", 0, 0, 0);
        uv_arm_i = 1'b1;
        step(UVW - 1);
        expect_out("R4", 0, 0, 0);
        step(1);
        expect_out("R4", 1, 3, 0);
        uv_flag_i = 1'b0;
        step(3);
        expect_out("R4", 1, 3, 0);
        toggle_enable();
        expect_out("R9", 0, 0, 0);
        uv_arm_i = 1'b0;
    endtask

    task automatic t_oc();
        for (int k = 1; k < OCN; k++) begin
            oc_pulse();
            expect_out("R5", 1, 0, 1);
            step(1);
            expect_out("R5", 0, 0, 0);
            step(20);  // idle gap; tally must survive (R7)
        end
        oc_pulse();
        expect_out("R6", 3, 4, 0);
        step(1);
        expect_out("R7", 3, 4, 0);
        oc_pulse();
        step(2);
        expect_out("R6", 3, 4, 0);
        bias_ok_i = 1'b0;
        step(1);
        bias_ok_i = 1'b1;
        expect_out("R9", 0, 0, 0);
        step(1);
        oc_pulse();
        expect_out("R9", 1, 0, 1);
        step(1);
        toggle_enable();
    endtask

    task automatic t_ot();
        ot_hot_i = 1'b1;
        step(1);
        expect_out("R8", 1, 2, 0);
        ot_hot_i = 1'b0;
        step(10);
        expect_out("R8", 1, 2, 0);
        ot_cool_i = 1'b1;
        step(1);
        ot_cool_i = 1'b0;
        expect_out("R8", 0, 0, 0);
    endtask

    task automatic t_prio();
        uv_arm_i  = 1'b1;
        uv_flag_i = 1'b1;
        step(UVW);
        expect_out("R10", 1, 3, 0);
        ot_hot_i = 1'b1;
        step(1);
        expect_out("R10", 1, 2, 0);
        ov_flag_i = 1'b1;
        step(OVW);
        expect_out("R10", 2, 1, 0);
        ot_hot_i  = 1'b0;
        ot_cool_i = 1'b1;
        step(1);
        ot_cool_i = 1'b0;
        expect_out("R10", 2, 1, 0);
        ov_flag_i = 1'b0;
        uv_flag_i = 1'b0;
        uv_arm_i  = 1'b0;
        en_i = 1'b0;
        step(1);
        expect_out("R9", 0, 0, 0);
        en_i = 1'b1;
        step(1);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_ov();
        t_filter_restart();
        t_uv();
        t_oc();
        t_ot();
        t_prio();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule